// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each has a low and a high byte register, a run bit, an external count pin and an external gate pin. A 4-bit configuration nibble sets each channel. Bit 3 enables gating and bit 2 selects counting of external pin edges instead of machine cycles. Bits 1:0 choose the structure: a 13-bit count with a 5-bit prescaler, a 16-bit count, an 8-bit count that reloads itself, or a split arrangement. The split arrangement applies to channel 0 only, and it turns channel 0 into two independent 8-bit counters. All counting advances only on cycles where the machine-cycle enable input is high.

A CPU-side wrapper loads and reads the four byte registers over plain parallel buses. Each channel raises a sticky overflow flag, which is cleared by a per-channel strobe. In timer use, the gate pin combined with gating lets software measure how long an external pulse stays high.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all four byte registers, both overflow flags and both edge samplers are 0.
- R2: A channel's main count advances only on a cycle with mc_en high, its run bit high, and either nibble bit 3 low or its gate input high. With mc_en low and no write, no register changes.
- R3: With nibble bit 2 low, an enabled channel advances once per mc_en cycle.
- R4: With nibble bit 2 high, the count input is sampled on each mc_en cycle. An advance occurs only when the previous sample is 1 and the current one is 0. Level changes between mc_en cycles are not seen.
- R5: Mode 00: bits 4:0 of the low byte form a prescaler. When the prescaler wraps from 31, the high byte increments. Low-byte bits 7:5 hold their value. The overflow flag is set when the high byte wraps from 0xFF.
- R6: Mode 01: {high,low} is a 16-bit count, and the flag is set on the wrap from 0xFFFF to 0x0000.
- R7: Mode 10: the low byte counts. On an advance from 0xFF it loads the high byte and sets the flag in the same cycle. The high byte is never changed by counting.
- R8: Mode 11 on channel 0: the low byte counts under channel 0's controls and sets flag 0 on wrap. The high byte counts every mc_en cycle while run1 is high, ignoring gating and bit 2, and sets flag 1 on wrap.
- R9: Mode 11 on channel 1 freezes both of its bytes. While channel 0 is in mode 11, channel 1 overflows do not set flag 1.
- R10: wr_sel addresses the bytes: 0 is ch0 low, 1 is ch0 high, 2 is ch1 low, 3 is ch1 high. A write loads the byte, and the addressed channel does not count in that cycle. rd_data shows the byte chosen by rd_sel combinationally.
- R11: The flags are sticky and are cleared by flag_clr[i]. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| mc_en | input | 1 | machine-cycle enable pulse |
| cfg0 | input | 4 | channel 0 nibble {gate, ext, mode[1:0]} |
| cfg1 | input | 4 | channel 1 nibble {gate, ext, mode[1:0]} |
| run0 | input | 1 | channel 0 run bit |
| run1 | input | 1 | channel 1 run bit (also split timer run) |
| cnt_in0 | input | 1 | channel 0 external count pin |
| cnt_in1 | input | 1 | channel 1 external count pin |
| gate_in0 | input | 1 | channel 0 gate pin |
| gate_in1 | input | 1 | channel 1 gate pin |
| wr_en | input | 1 | byte write strobe |
| wr_sel | input | 2 | byte address for writes |
| wr_data | input | 8 | write data |
| rd_sel | input | 2 | byte address for reads |
| rd_data | output | 8 | selected byte |
| flag_clr | input | 2 | per-channel flag clear strobe |
| ovf0 | output | 1 | channel 0 overflow flag |
| ovf1 | output | 1 | channel 1 overflow flag |

## Verification
The assertions assume that every input is synchronous to clk and stable at the rising edge. They place no limit on how often mc_en pulses, how configuration nibbles change, or when writes collide with counting. The bench drives all inputs just after the falling edge and mixes directed sequences with random ones. The random stimulus pulses mc_en on about half the cycles, changes nibbles and run bits rarely, and toggles the pins freely. This exercises gated, edge-counted, reloading and split behaviour under collisions between writes and counting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MD_PRE13  = 2'b00,
      MD_W16    = 2'b01,
      MD_RELOAD = 2'b10,
      MD_SPLIT  = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      logic      gate;
      logic      ext;
      tmr_mode_e md;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_en,
   input  logic din,
   output logic fall
);
   logic smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     smp_q <= 1'b0;
      else if (mc_en) smp_q <= din;
   end

   assign fall = mc_en & smp_q & ~din;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int PRE_W    = 5,
   parameter bit SPLIT_OK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_en,
   input  tmr_cfg_t          cfg,
   input  logic              run,
   input  logic              gin,
   input  logic              fall,
   input  logic              aux_run,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              ovf_main,
   output logic              ovf_aux
);
   localparam int WIDE_W = 2 * BYTE_W;

   if (PRE_W >= BYTE_W) begin : g_bad_pre
      $error("PRE_W must be narrower than BYTE_W");
   end

   logic              cnt_ok;
   logic              aux_tick;
   logic              wr_any;
   logic [BYTE_W-1:0] lo_d, hi_d;
   logic [WIDE_W-1:0] wide_nx;

   assign cnt_ok  = mc_en & run & (~cfg.gate | gin) & (cfg.ext ? fall : 1'b1);
   assign wr_any  = wr_lo | wr_hi;
   assign wide_nx = {hi_q, lo_q} + 1'b1;

   if (SPLIT_OK) begin : g_split
      assign aux_tick = mc_en & aux_run;
   end else begin : g_nosplit
      logic unused_aux;
      assign unused_aux = aux_run;
      assign aux_tick   = 1'b0;
   end

   always_comb begin
      lo_d     = lo_q;
      hi_d     = hi_q;
      ovf_main = 1'b0;
      ovf_aux  = 1'b0;
      if (wr_any) begin
         if (wr_lo) lo_d = wr_data;
         if (wr_hi) hi_d = wr_data;
      end else begin
         case (cfg.md)
            MD_PRE13: if (cnt_ok) begin
               if (&lo_q[PRE_W-1:0]) begin
                  lo_d[PRE_W-1:0] = '0;
                  hi_d            = hi_q + 1'b1;
                  ovf_main        = &hi_q;
               end else begin
                  lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
               end
            end
            MD_W16: if (cnt_ok) begin
               {hi_d, lo_d} = wide_nx;
               ovf_main     = &{hi_q, lo_q};
            end
            MD_RELOAD: if (cnt_ok) begin
               if (&lo_q) begin
                  lo_d     = hi_q;
                  ovf_main = 1'b1;
               end else begin
                  lo_d = lo_q + 1'b1;
               end
            end
            MD_SPLIT: if (SPLIT_OK) begin
               if (cnt_ok) begin
                  lo_d     = lo_q + 1'b1;
                  ovf_main = &lo_q;
               end
               if (aux_tick) begin
                  hi_d    = hi_q + 1'b1;
                  ovf_aux = &hi_q;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_en && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));

   a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.gate && !gin && cfg.md != MD_SPLIT && !wr_any) |=> $stable({hi_q, lo_q}));

   a_r5_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.md == MD_PRE13 && !wr_lo) |=> $stable(lo_q[BYTE_W-1:PRE_W]));

   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.md == MD_RELOAD && ovf_main) |=> (lo_q == $past(hi_q)));

   a_r7_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.md == MD_RELOAD && !wr_hi) |=> $stable(hi_q));

   if (SPLIT_OK) begin : g_chk_split
      a_r8_aux_timer: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg.md == MD_SPLIT && !wr_any && mc_en && aux_run) |=> (hi_q == $past(hi_q) + 1'b1));
   end else begin : g_chk_stop
      a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg.md == MD_SPLIT && !wr_any) |=> $stable({hi_q, lo_q}));
   end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_en,
   input  logic [3:0]        cfg0,
   input  logic [3:0]        cfg1,
   input  logic              run0,
   input  logic              run1,
   input  logic              cnt_in0,
   input  logic              cnt_in1,
   input  logic              gate_in0,
   input  logic              gate_in1,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [1:0]        flag_clr,
   output logic              ovf0,
   output logic              ovf1
);
   localparam int NCH = 2;

   if ($bits(tmr_cfg_t) != 4) begin : g_bad_cfg
      $error("configuration nibble must be 4 bits");
   end

   tmr_cfg_t          cfg_v  [NCH];
   logic [NCH-1:0]    run_v, cin_v, gin_v, fall_v, main_ovf, aux_ovf;
   logic [BYTE_W-1:0] lo_v   [NCH];
   logic [BYTE_W-1:0] hi_v   [NCH];
   logic              split0, set0, set1, unused_aux1;

   assign cfg_v[0] = tmr_cfg_t'(cfg0);
   assign cfg_v[1] = tmr_cfg_t'(cfg1);
   assign run_v    = {run1, run0};
   assign cin_v    = {cnt_in1, cnt_in0};
   assign gin_v    = {gate_in1, gate_in0};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic sel_ch;
      assign sel_ch = wr_en & (wr_sel[1] == ch[0]);

      tmr_edge i_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .mc_en (mc_en),
         .din   (cin_v[ch]),
         .fall  (fall_v[ch])
      );

      tmr_chan #(
         .BYTE_W   (BYTE_W),
         .PRE_W    (PRE_W),
         .SPLIT_OK (ch == 0)
      ) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .mc_en    (mc_en),
         .cfg      (cfg_v[ch]),
         .run      (run_v[ch]),
         .gin      (gin_v[ch]),
         .fall     (fall_v[ch]),
         .aux_run  (run1),
         .wr_lo    (sel_ch & ~wr_sel[0]),
         .wr_hi    (sel_ch & wr_sel[0]),
         .wr_data  (wr_data),
         .lo_q     (lo_v[ch]),
         .hi_q     (hi_v[ch]),
         .ovf_main (main_ovf[ch]),
         .ovf_aux  (aux_ovf[ch])
      );
   end

   assign unused_aux1 = aux_ovf[1];
   assign split0      = (cfg_v[0].md == MD_SPLIT);
   assign set0        = main_ovf[0];
   assign set1        = split0 ? aux_ovf[0] : main_ovf[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf0 <= 1'b0;
         ovf1 <= 1'b0;
      end else begin
         ovf0 <= set0 | (ovf0 & ~flag_clr[0]);
         ovf1 <= set1 | (ovf1 & ~flag_clr[1]);
      end
   end

   always_comb begin
      rd_data = rd_sel[0] ? hi_v[rd_sel[1]] : lo_v[rd_sel[1]];
   end

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      main_ovf[0] |=> ovf0);

   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[0] && !main_ovf[0]) |=> !ovf0);

   a_r9_no_ch1_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && !aux_ovf[0] && !ovf1) |=> !ovf1);

   a_r8_aux_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (split0 && aux_ovf[0]) |=> ovf1);
endmodule

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
   logic       clk = 1'b0;
   logic       rst_n, mc_en, run0, run1, cnt_in0, cnt_in1, gate_in0, gate_in1, wr_en;
   logic [3:0] cfg0, cfg1;
   logic [1:0] wr_sel, rd_sel, flag_clr;
   logic [7:0] wr_data, rd_data;
   logic       ovf0, ovf1;

   always #10 clk = ~clk;

   tmr_pair i_tmr_pair (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cfg0(cfg0), .cfg1(cfg1),
      .run0(run0), .run1(run1), .cnt_in0(cnt_in0), .cnt_in1(cnt_in1),
      .gate_in0(gate_in0), .gate_in1(gate_in1), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .flag_clr(flag_clr), .ovf0(ovf0), .ovf1(ovf1)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference model, built from the requirements
   logic [7:0] m_lo [2];
   logic [7:0] m_hi [2];
   logic       m_smp[2];
   logic       m_f  [2];
   logic       om [2];
   logic       oa, fl, en;
   logic [3:0] cf;
   logic [1:0] rv, cv, gv;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_lo[i] = 0; m_hi[i] = 0; m_smp[i] = 0; m_f[i] = 0;
         end
      end else begin
         rv = {run1, run0}; cv = {cnt_in1, cnt_in0}; gv = {gate_in1, gate_in0};
         oa = 0;
         for (int i = 0; i < 2; i++) begin
            om[i] = 0;
            fl = mc_en && m_smp[i] && !cv[i];
            if (mc_en) m_smp[i] = cv[i];
            cf = (i == 0) ? cfg0 : cfg1;
            en = mc_en && rv[i] && (!cf[3] || gv[i]) && (cf[2] ? fl : 1'b1);
            if (wr_en && wr_sel[1] == 1'(i)) begin
               if (wr_sel[0]) m_hi[i] = wr_data; else m_lo[i] = wr_data;
            end else begin
               case (cf[1:0])
                  2'b00: if (en) begin
                     if (m_lo[i][4:0] == 5'd31) begin
                        m_lo[i][4:0] = 0; om[i] = (m_hi[i] == 8'hFF); m_hi[i] = m_hi[i] + 1;
                     end else m_lo[i][4:0] = m_lo[i][4:0] + 1;
                  end
                  2'b01: if (en) begin
                     om[i] = ({m_hi[i], m_lo[i]} == 16'hFFFF);
                     {m_hi[i], m_lo[i]} = {m_hi[i], m_lo[i]} + 16'd1;
                  end
                  2'b10: if (en) begin
                     if (m_lo[i] == 8'hFF) begin m_lo[i] = m_hi[i]; om[i] = 1; end
                     else m_lo[i] = m_lo[i] + 1;
                  end
                  default: if (i == 0) begin
                     if (en) begin om[0] = (m_lo[0] == 8'hFF); m_lo[0] = m_lo[0] + 1; end
                     if (mc_en && run1) begin oa = (m_hi[0] == 8'hFF); m_hi[0] = m_hi[0] + 1; end
                  end
               endcase
            end
         end
         m_f[0] = om[0] | (m_f[0] & !flag_clr[0]);
         m_f[1] = ((cfg0[1:0] == 2'b11) ? oa : om[1]) | (m_f[1] & !flag_clr[1]);
      end
   end

   function automatic logic [7:0] exp_byte(int s);
      return s[0] ? m_hi[s/2] : m_lo[s/2];
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(int s, output logic [7:0] v);
      rd_sel = 2'(s); #1; v = rd_data;
   endtask

   task automatic cmp_all(string tag);
      logic [7:0] v;
      for (int s = 0; s < 4; s++) begin
         rd(s, v); chk(tag, 16'(v), 16'(exp_byte(s)));
      end
      chk(tag, 16'(ovf0), 16'(m_f[0]));
      chk(tag, 16'(ovf1), 16'(m_f[1]));
   endtask

   task automatic ticks(int n, logic mc);
      repeat (n) begin mc_en = mc; @(negedge clk); end
      mc_en = 0;
   endtask

   task automatic wr_b(logic [1:0] s, logic [7:0] d);
      wr_en = 1; wr_sel = s; wr_data = d; @(negedge clk); wr_en = 0;
   endtask

   task automatic clr(logic [1:0] c);
      flag_clr = c; @(negedge clk); flag_clr = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4711));
      rst_n = 0; mc_en = 0; cfg0 = 0; cfg1 = 0; run0 = 0; run1 = 0;
      cnt_in0 = 0; cnt_in1 = 0; gate_in0 = 0; gate_in1 = 0;
      wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; flag_clr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      for (int s = 0; s < 4; s++) begin rd(s, v); chk("R1 reset byte", 16'(v), 16'h0); end
      chk("R1 reset flags", {14'b0, ovf1, ovf0}, 16'h0);

      // R3 timer counting
      cfg0 = 4'b0001; run0 = 1;
      ticks(10, 1); rd(0, v); chk("R3 timer ten cycles", 16'(v), 16'd10);
      ticks(5, 0);  rd(0, v); chk("R2 no mc_en", 16'(v), 16'd10);

      // R2 gating
      cfg0 = 4'b1001; gate_in0 = 0;
      ticks(6, 1); rd(0, v); chk("R2 gate closed", 16'(v), 16'd10);
      gate_in0 = 1;
      ticks(3, 1); rd(0, v); chk("R2 gate open", 16'(v), 16'd13);
      run0 = 0;
      ticks(3, 1); rd(0, v); chk("R2 run low", 16'(v), 16'd13);

      // R4 edge counting
      cfg0 = 4'b0101; run0 = 1;
      cnt_in0 = 1; ticks(1, 1);
      cnt_in0 = 0; ticks(1, 1); rd(0, v); chk("R4 falling edge", 16'(v), 16'd14);
      ticks(2, 1); rd(0, v); chk("R4 steady low", 16'(v), 16'd14);
      cnt_in0 = 1; ticks(2, 0);
      cnt_in0 = 0; ticks(1, 1); rd(0, v); chk("R4 unsampled pulse", 16'(v), 16'd14);
      cnt_in0 = 1; ticks(1, 1); cnt_in0 = 0; ticks(1, 1);
      rd(0, v); chk("R4 second edge", 16'(v), 16'd15);
      cmp_all("R4 model");

      // R5 prescaled mode
      cfg0 = 4'b0000;
      wr_b(2'd0, 8'hBE); wr_b(2'd1, 8'hFF);
      ticks(1, 1); rd(0, v); chk("R5 prescaler step", 16'(v), 16'hBF);
      chk("R5 no flag yet", 16'(ovf0), 16'h0);
      ticks(1, 1); rd(0, v); chk("R5 prescaler wrap keeps top bits", 16'(v), 16'hA0);
      rd(1, v); chk("R5 high wrap", 16'(v), 16'h00);
      chk("R5 flag", 16'(ovf0), 16'h1);
      clr(2'b01); chk("R11 clear", 16'(ovf0), 16'h0);

      // R6 16-bit on channel 1
      cfg1 = 4'b0001; run1 = 1;
      wr_b(2'd2, 8'hFE); wr_b(2'd3, 8'hFF);
      ticks(1, 1); chk("R6 no flag at FFFF", 16'(ovf1), 16'h0);
      ticks(1, 1); rd(2, v); chk("R6 low wrap", 16'(v), 16'h00);
      rd(3, v); chk("R6 high wrap", 16'(v), 16'h00);
      chk("R6 flag", 16'(ovf1), 16'h1);

      // R7 reload
      cfg0 = 4'b0010;
      wr_b(2'd1, 8'h80); wr_b(2'd0, 8'hFE);
      ticks(2, 1); rd(0, v); chk("R7 reload value", 16'(v), 16'h80);
      chk("R7 flag", 16'(ovf0), 16'h1);
      ticks(1, 1); rd(0, v); chk("R7 after reload", 16'(v), 16'h81);
      rd(1, v); chk("R7 high kept", 16'(v), 16'h80);

      // R11 set beats clear
      clr(2'b01); chk("R11 clear alone", 16'(ovf0), 16'h0);
      wr_b(2'd0, 8'hFF);
      flag_clr = 2'b01; mc_en = 1; @(negedge clk); flag_clr = 0; mc_en = 0;
      chk("R11 set wins", 16'(ovf0), 16'h1);

      // R8 split mode, R9 channel 1 suppressed
      cfg0 = 4'b1111; run0 = 0; gate_in0 = 0; cfg1 = 4'b0001; run1 = 1;
      clr(2'b11);
      wr_b(2'd1, 8'hFE); wr_b(2'd2, 8'hFF); wr_b(2'd3, 8'hFF);
      ticks(1, 1); chk("R9 ch1 wrap suppressed", 16'(ovf1), 16'h0);
      ticks(1, 1); rd(1, v); chk("R8 aux timer wrap", 16'(v), 16'h00);
      chk("R8 aux sets flag 1", 16'(ovf1), 16'h1);
      chk("R8 flag 0 untouched", 16'(ovf0), 16'h0);
      rd(0, v); chk("R8 low held by run0", 16'(v), 16'h80);
      cfg1 = 4'b0011;
      ticks(3, 1); rd(2, v); chk("R9 ch1 frozen low", 16'(v), 16'h01);
      rd(3, v); chk("R9 ch1 frozen high", 16'(v), 16'h00);
      cmp_all("R8 model");

      // R10 write beats count
      cfg0 = 4'b0001; run0 = 1;
      wr_en = 1; wr_sel = 2'd0; wr_data = 8'h40; mc_en = 1;
      @(negedge clk); wr_en = 0; mc_en = 0;
      rd(0, v); chk("R10 write blocks count", 16'(v), 16'h40);
      cmp_all("R10 model");

      // random phase
      for (int n = 0; n < 3000; n++) begin
         cmp_all("RAND model");
         mc_en    = $urandom_range(1, 0);
         cnt_in0  = $urandom_range(1, 0);
         cnt_in1  = $urandom_range(1, 0);
         gate_in0 = ($urandom_range(3, 0) != 0);
         gate_in1 = ($urandom_range(3, 0) != 0);
         if ($urandom_range(63, 0) == 0) cfg0 = 4'($urandom);
         if ($urandom_range(63, 0) == 0) cfg1 = 4'($urandom);
         if ($urandom_range(31, 0) == 0) run0 = ~run0;
         if ($urandom_range(31, 0) == 0) run1 = ~run1;
         wr_en    = ($urandom_range(15, 0) == 0);
         wr_sel   = 2'($urandom);
         wr_data  = ($urandom_range(1, 0) == 1) ? 8'hFF - 8'($urandom_range(2, 0)) : 8'($urandom);
         flag_clr = ($urandom_range(7, 0) == 0) ? 2'($urandom) : 2'b00;
         @(negedge clk);
      end
      cmp_all("RAND final");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule